// File: doc/BRIEF.md
# Trace Record Buffer with Selectable Overflow Policy

This block takes trace records from a processor's trace output, holds them in a small FIFO and moves them into a circular trace memory. It moves one entry per cycle whenever the memory write slot is granted. A host reads the memory through a plain address/data port. The host uses the write pointer and a sticky wrapped flag to find the oldest surviving entry.

When the FIFO is full, a mode input picks what happens. In real-time mode the processor is never held. Records that arrive while the FIFO is full are discarded, and any run of discarded records becomes one overflow marker entry. The marker is tagged by a flag bit and carries the number of records lost. In non-real-time mode the block raises a stall to the processor, which holds its record until a slot frees. The stall then drops on its own, so no record is lost.

Each memory entry is DW+1 bits wide. Bit DW is the marker flag: 0 means a trace record and 1 means an overflow marker. Bits DW-1:0 hold the record payload, or for a marker the count of lost records.

Top module: `tf_trace_buffer`

## Requirements
- R1: After reset, wr_ptr_o is 0, wrapped_o is 0, stall_o is 0 and push_ready_o is 1.
- R2: Accepted records reach the memory in arrival order, with the marker flag (bit DW) at 0 and the payload unchanged in bits DW-1:0.
- R3: With nrt_mode_i low, stall_o stays 0 and push_ready_o stays 1. A record offered while the FIFO holds DEPTH entries is discarded.
- R4: A run of consecutive discarded records produces exactly one marker entry. The marker has bit DW at 1 and bits DW-1:0 equal to the number of records lost, saturating at 2^DW-1. It follows the last record accepted before the run and precedes every record accepted after it.
- R5: A pending marker is written into the first FIFO slot that frees. A record offered in that same cycle is discarded and opens a new run, which yields its own marker.
- R6: With nrt_mode_i high, stall_o is 1 exactly when push_valid_i is 1 and push_ready_o is 0. push_ready_o is 0 while the FIFO is full. No record is discarded in this mode.
- R7: A pop from a full FIFO does not clear the stall in its own cycle. The stall clears in the following cycle, when no marker is pending.
- R8: When drain_en_i is 1 and the FIFO is non-empty, exactly one entry is written per cycle. When the FIFO is empty, nothing is written and wr_ptr_o holds its value.
- R9: wr_ptr_o is the address of the next write. After address MEM_DEPTH-1 it returns to 0 and sets wrapped_o, which then stays 1 until reset. Once wrapped, the entry at wr_ptr_o is the oldest and later writes overwrite it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nrt_mode_i | input | 1 | 1: stall on full FIFO; 0: discard and mark |
| push_valid_i | input | 1 | Trace record offered |
| push_data_i | input | DW | Trace record payload |
| push_ready_o | output | 1 | Record is taken at this edge (always 1 in real-time mode) |
| stall_o | output | 1 | Hold request to the processor |
| drain_en_i | input | 1 | Memory write slot granted this cycle |
| rd_addr_i | input | AW | Host read address |
| rd_data_o | output | DW+1 | Entry at rd_addr_i, marker flag in the top bit |
| wr_ptr_o | output | AW | Next memory write address |
| wrapped_o | output | 1 | Memory has wrapped at least once |

## Verification
A FIFO count that goes wrong shows up at the FIFO's edges. In real-time mode the marker would appear one record early or late, or carry the wrong loss count. In non-real-time mode stall_o would rise or fall a cycle off, or a held record would be dropped. A wrong pending-marker state leaves a missing or duplicated marker entry in the memory as soon as the FIFO drains. Pointer or wrap faults appear in wr_ptr_o and wrapped_o at the write that crosses the last address, and in the entry a host reads there.

// File: rtl/tf_pkg.sv
package tf_pkg;
  // What happens to an offered record in a given cycle
  typedef enum logic [1:0] {
    ARR_IDLE = 2'd0,
    ARR_TAKE = 2'd1,
    ARR_DROP = 2'd2,
    ARR_HOLD = 2'd3
  } arrival_e;
endpackage

// File: rtl/tf_fifo.sv
module tf_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [W-1:0]                 wr_data_i,
  input  logic                         rd_en_i,
  output logic [W-1:0]                 rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  logic do_wr, do_rd;
  assign do_wr = wr_en_i && !full_o;
  assign do_rd = rd_en_i && !empty_o;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (do_wr) begin
      slot_q[wp_q] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= ptr_inc(wp_q);
      if (do_rd) rp_q <= ptr_inc(rp_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = slot_q[rp_q];
  assign cnt_o     = cnt_q;
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
endmodule

// File: rtl/tf_ovf_ctrl.sv
module tf_ovf_ctrl
  import tf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nrt_mode_i,
  input  logic          push_valid_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          fifo_full_i,
  output logic          push_ready_o,
  output logic          stall_o,
  output logic          fifo_wr_o,
  output logic [DW:0]   fifo_wdata_o,
  output logic          mk_pend_o
);
  logic          mk_pend_q;
  logic [DW-1:0] mk_cnt_q;
  logic          ins_mk;
  arrival_e      arr;

  // marker owns the first freed slot
  assign ins_mk = mk_pend_q && !fifo_full_i;

  always_comb begin
    if (!push_valid_i)                    arr = ARR_IDLE;
    else if (!fifo_full_i && !ins_mk)     arr = ARR_TAKE;
    else if (nrt_mode_i)                  arr = ARR_HOLD;
    else                                  arr = ARR_DROP;
  end

  assign push_ready_o = nrt_mode_i ? (!fifo_full_i && !ins_mk) : 1'b1;
  assign stall_o      = (arr == ARR_HOLD);
  assign fifo_wr_o    = ins_mk || (arr == ARR_TAKE);
  assign fifo_wdata_o = ins_mk ? {1'b1, mk_cnt_q} : {1'b0, push_data_i};
  assign mk_pend_o    = mk_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mk_pend_q <= 1'b0;
      mk_cnt_q  <= '0;
    end else if (ins_mk) begin
      mk_pend_q <= (arr == ARR_DROP);
      mk_cnt_q  <= (arr == ARR_DROP) ? DW'(1) : '0;
    end else if (arr == ARR_DROP) begin
      mk_pend_q <= 1'b1;
      if (!(&mk_cnt_q)) mk_cnt_q <= mk_cnt_q + DW'(1);
    end
  end
endmodule

// File: rtl/tf_trace_mem.sv
module tf_trace_mem #(
  parameter int W         = 9,
  parameter int MEM_DEPTH = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [W-1:0]                  wdata_i,
  input  logic [$clog2(MEM_DEPTH)-1:0]  rd_addr_i,
  output logic [W-1:0]                  rd_data_o,
  output logic [$clog2(MEM_DEPTH)-1:0]  wr_ptr_o,
  output logic                          wrapped_o
);
  localparam int AW = $clog2(MEM_DEPTH);

  logic [W-1:0]  word_q [MEM_DEPTH];
  logic [AW-1:0] ptr_q;
  logic          wrap_q;
  logic          at_end;

  assign at_end = (ptr_q == AW'(MEM_DEPTH-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) word_q[i] <= '0;
    end else if (we_i) begin
      word_q[ptr_q] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (we_i) begin
      ptr_q <= at_end ? '0 : ptr_q + AW'(1);
      if (at_end) wrap_q <= 1'b1;
    end
  end

  assign rd_data_o = (int'(rd_addr_i) < MEM_DEPTH) ? word_q[rd_addr_i] : '0;
  assign wr_ptr_o  = ptr_q;
  assign wrapped_o = wrap_q;
endmodule

// File: rtl/tf_trace_buffer.sv
module tf_trace_buffer #(
  parameter int DW        = 8,
  parameter int DEPTH     = 8,
  parameter int MEM_DEPTH = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          nrt_mode_i,
  input  logic                          push_valid_i,
  input  logic [DW-1:0]                 push_data_i,
  output logic                          push_ready_o,
  output logic                          stall_o,
  input  logic                          drain_en_i,
  input  logic [$clog2(MEM_DEPTH)-1:0]  rd_addr_i,
  output logic [DW:0]                   rd_data_o,
  output logic [$clog2(MEM_DEPTH)-1:0]  wr_ptr_o,
  output logic                          wrapped_o
);
  localparam int EW = DW + 1;
  localparam int CW = $clog2(DEPTH+1);

  logic          fifo_wr, fifo_full, fifo_empty, fifo_pop, mk_pend;
  logic [EW-1:0] fifo_wdata, fifo_rdata;
  logic [CW-1:0] fifo_cnt;

  assign fifo_pop = drain_en_i && !fifo_empty;

  tf_ovf_ctrl #(.DW(DW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .nrt_mode_i   (nrt_mode_i),
    .push_valid_i (push_valid_i),
    .push_data_i  (push_data_i),
    .fifo_full_i  (fifo_full),
    .push_ready_o (push_ready_o),
    .stall_o      (stall_o),
    .fifo_wr_o    (fifo_wr),
    .fifo_wdata_o (fifo_wdata),
    .mk_pend_o    (mk_pend)
  );

  tf_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (fifo_wr),
    .wr_data_i (fifo_wdata),
    .rd_en_i   (fifo_pop),
    .rd_data_o (fifo_rdata),
    .cnt_o     (fifo_cnt),
    .full_o    (fifo_full),
    .empty_o   (fifo_empty)
  );

  tf_trace_mem #(.W(EW), .MEM_DEPTH(MEM_DEPTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (fifo_pop),
    .wdata_i   (fifo_rdata),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .wr_ptr_o  (wr_ptr_o),
    .wrapped_o (wrapped_o)
  );
endmodule

// File: rtl/tf_trace_buffer_chk.sv
module tf_trace_buffer_chk #(
  parameter int DEPTH     = 8,
  parameter int MEM_DEPTH = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          nrt_mode_i,
  input logic                          push_valid_i,
  input logic                          push_ready_o,
  input logic                          stall_o,
  input logic [$clog2(MEM_DEPTH)-1:0]  wr_ptr_o,
  input logic                          wrapped_o,
  input logic [$clog2(DEPTH+1)-1:0]    fifo_cnt,
  input logic                          fifo_pop,
  input logic                          mk_pend
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  assert_rt_never_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nrt_mode_i |-> (!stall_o && push_ready_o));

  assert_stall_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (nrt_mode_i && push_valid_i && !push_ready_o));

  assert_stall_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CW'(DEPTH) && fifo_pop && !mk_pend) |=> !stall_o);

  assert_empty_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == '0) |=> $stable(wr_ptr_o));

  assert_ptr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_ptr_o) |-> (wr_ptr_o == (($past(wr_ptr_o) == AW'(MEM_DEPTH-1)) ?
                                          AW'(0) : $past(wr_ptr_o) + AW'(1))));

  assert_wrap_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrapped_o |=> wrapped_o);

  assert_wrap_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_o == '0 && $past(wr_ptr_o) == AW'(MEM_DEPTH-1)) |-> wrapped_o);

  assert_fifo_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));
endmodule

bind tf_trace_buffer tf_trace_buffer_chk #(.DEPTH(DEPTH), .MEM_DEPTH(MEM_DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .nrt_mode_i   (nrt_mode_i),
  .push_valid_i (push_valid_i),
  .push_ready_o (push_ready_o),
  .stall_o      (stall_o),
  .wr_ptr_o     (wr_ptr_o),
  .wrapped_o    (wrapped_o),
  .fifo_cnt     (fifo_cnt),
  .fifo_pop     (fifo_pop),
  .mk_pend      (mk_pend)
);

// File: tb/tf_trace_buffer_bench.sv
module tf_trace_buffer_bench;
  localparam int DW = 8, DEPTH = 8, MEM_DEPTH = 16;
  localparam int AW = $clog2(MEM_DEPTH);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic nrt_mode_i = 1'b0, push_valid_i = 1'b0, drain_en_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic push_ready_o, stall_o, wrapped_o;
  logic [AW-1:0] rd_addr_i, wr_ptr_o, mon_addr = '0, host_addr = '0, mon_prev = '0;
  logic host_sel = 1'b0;
  logic [DW:0] rd_data_o;

  int errs = 0, checks = 0, cycles = 0;
  logic [DW:0] sb[$];
  logic [DW:0] hist[$];

  always #4 clk = ~clk;
  assign rd_addr_i = host_sel ? host_addr : mon_addr;

  tf_trace_buffer #(.DW(DW), .DEPTH(DEPTH), .MEM_DEPTH(MEM_DEPTH)) u_tf_trace_buffer (
    .clk_i(clk), .rst_ni(rst_ni), .nrt_mode_i(nrt_mode_i),
    .push_valid_i(push_valid_i), .push_data_i(push_data_i),
    .push_ready_o(push_ready_o), .stall_o(stall_o), .drain_en_i(drain_en_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wr_ptr_o(wr_ptr_o), .wrapped_o(wrapped_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW:0] rec(input logic [DW-1:0] d); return {1'b0, d}; endfunction
  function automatic logic [DW:0] mk(input logic [DW-1:0] n);  return {1'b1, n}; endfunction

  // monitor: each pointer step is one memory write, compared against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && wr_ptr_o != mon_prev) begin
      mon_addr = mon_prev;
      #1;
      if (sb.size() == 0) chk("R8 unexpected write", {23'd0, rd_data_o}, 32'h1ff);
      else begin
        logic [DW:0] e;
        e = sb.pop_front();
        chk("R2/R4 entry", {23'd0, rd_data_o}, {23'd0, e});
        hist.push_back(e);
      end
      mon_prev = wr_ptr_o;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // real-time push: one record per cycle, drain grant chosen per cycle
  task automatic rt_push(input logic [DW-1:0] d, input logic dr);
    @(negedge clk);
    push_valid_i = 1'b1; push_data_i = d; drain_en_i = dr;
    #1;
    chk("R3 stall", {31'd0, stall_o}, 0);
    chk("R3 ready", {31'd0, push_ready_o}, 1);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); push_valid_i = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_drain();
    @(negedge clk); push_valid_i = 1'b0; drain_en_i = 1'b1;
    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    chk("R8 drained", sb.size(), 0);
  endtask

  task automatic nrt_push(input logic [DW-1:0] d);
    @(negedge clk);
    push_valid_i = 1'b1; push_data_i = d;
    #1;
    while (!push_ready_o) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  initial begin
    drain_en_i = 1'b1;
    #1;
    chk("R1 ptr", {28'd0, wr_ptr_o}, 0);
    chk("R1 wrapped", {31'd0, wrapped_o}, 0);
    chk("R1 stall", {31'd0, stall_o}, 0);
    chk("R1 ready", {31'd0, push_ready_o}, 1);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R8: drain granted on empty FIFO writes nothing
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8 empty ptr", {28'd0, wr_ptr_o}, 0);

    // R2: streaming records with drain on
    for (int i = 0; i < 5; i++) begin sb.push_back(rec(DW'(8'h10 + i))); rt_push(DW'(8'h10 + i), 1'b1); end
    wait_drain();
    chk("R9 ptr after 5", {28'd0, wr_ptr_o}, 5);
    chk("R9 not wrapped", {31'd0, wrapped_o}, 0);

    // R4: fill, lose three, one marker
    for (int i = 0; i < DEPTH; i++) begin sb.push_back(rec(DW'(8'h20 + i))); rt_push(DW'(8'h20 + i), 1'b0); end
    for (int i = 0; i < 3; i++) rt_push(8'hEE, 1'b0);
    sb.push_back(mk(8'd3));
    idle(2);
    wait_drain();

    // R5: marker takes the freed slot, concurrent record starts a new run
    @(negedge clk); drain_en_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin sb.push_back(rec(DW'(8'h50 + i))); rt_push(DW'(8'h50 + i), 1'b0); end
    rt_push(8'hE1, 1'b0);
    rt_push(8'hE2, 1'b0);
    rt_push(8'hE3, 1'b1);   // pop and drop in the same cycle
    rt_push(8'hE4, 1'b0);   // marker inserted, this one lost
    sb.push_back(mk(8'd3));
    sb.push_back(mk(8'd1));
    idle(1);
    wait_drain();

    // R4: loss count saturates, later records follow the marker
    @(negedge clk); drain_en_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin sb.push_back(rec(DW'(8'h70 + i))); rt_push(DW'(8'h70 + i), 1'b0); end
    for (int i = 0; i < 300; i++) rt_push(8'hDD, 1'b0);
    sb.push_back(mk(8'hFF));
    idle(1);
    wait_drain();
    sb.push_back(rec(8'h91)); rt_push(8'h91, 1'b1);
    sb.push_back(rec(8'h92)); rt_push(8'h92, 1'b1);
    wait_drain();

    // R6/R7: stall mode
    @(negedge clk); drain_en_i = 1'b0; nrt_mode_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin sb.push_back(rec(DW'(8'hA0 + i))); nrt_push(DW'(8'hA0 + i)); end
    @(negedge clk);
    push_valid_i = 1'b1; push_data_i = 8'hA8; sb.push_back(rec(8'hA8));
    #1;
    chk("R6 stall when full", {31'd0, stall_o}, 1);
    chk("R6 ready when full", {31'd0, push_ready_o}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 stall held", {31'd0, stall_o}, 1);
    drain_en_i = 1'b1;
    #1;
    chk("R7 stall in pop cycle", {31'd0, stall_o}, 1);
    @(negedge clk);
    drain_en_i = 1'b0;
    #1;
    chk("R7 stall released", {31'd0, stall_o}, 0);
    chk("R7 ready released", {31'd0, push_ready_o}, 1);
    @(posedge clk);
    @(negedge clk); drain_en_i = 1'b1;
    sb.push_back(rec(8'hA9)); nrt_push(8'hA9);
    sb.push_back(rec(8'hAA)); nrt_push(8'hAA);
    wait_drain();
    @(negedge clk); push_valid_i = 1'b0;
    #1;
    chk("R6 no stall without push", {31'd0, stall_o}, 0);

    // R9: wrap position and oldest entry
    @(negedge clk); drain_en_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 ptr", {28'd0, wr_ptr_o}, hist.size() % MEM_DEPTH);
    chk("R9 wrapped", {31'd0, wrapped_o}, 1);
    host_sel = 1'b1; host_addr = wr_ptr_o;
    #1;
    chk("R9 oldest entry", {23'd0, rd_data_o}, {23'd0, hist[hist.size() - MEM_DEPTH]});
    host_addr = wr_ptr_o - AW'(1);
    #1;
    chk("R9 newest entry", {23'd0, rd_data_o}, {23'd0, hist[hist.size() - 1]});
    host_sel = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule